// File: doc/BRIEF.md
# Shift-Add and Field Extract Unit

This unit is one execution slice of a 32-bit integer pipeline that has no hardware multiplier. It performs four addition-style operations: a plain add and three fused forms that shift the first operand left by 1, 2 or 3 bits before adding the second. Because these fused forms exist, a multiplication by a constant can be compiled into a short chain of single-cycle operations. For example, ten times x is computed as x·4+x, and that result is then added to itself.

The same unit also pulls a bit field out of a word and right-justifies it. The field can be filled with zeros or with copies of its own sign bit. Bit positions are numbered from the most significant end, so position 0 is the MSB and position 31 is the LSB. The position operand names the rightmost bit of the field. A field that would extend past bit 0 is clipped there.

The result can leave through a register stage or straight from the combinational logic, depending on a parameter. Register access, decode and overflow trapping belong to neighbouring blocks.

Top module: `sae_unit`

## Requirements
- R1: Opcode 0 (add) yields result = (src_a + src_b) mod 2^32. carry_out is the carry out of bit 31.
- R2: Opcodes 1, 2 and 3 yield result = ((src_a << n) mod 2^32 + src_b) mod 2^32, where n equals the opcode. carry_out is the carry out of that 32-bit addition. Bits shifted out of the operand do not reach carry_out.
- R3: Opcode 0 with the same value on both operands returns that value doubled, mod 2^32.
- R4: In an extract, bit position 0 is the MSB and position 31 is the LSB. fld_pos names the rightmost bit of the field. The field is len = fld_len_m1 + 1 bits wide and ends at fld_pos. It is returned right-justified, with the bit at fld_pos in result bit 0.
- R5: Opcode 4 (unsigned extract) fills every result bit above the field with 0.
- R6: Opcode 5 (signed extract) fills every result bit above the field with the leftmost field bit. With fld_pos = 31 and len = 16, the result is the low halfword of src_a, sign-extended.
- R7: When len exceeds fld_pos + 1, the field is clipped at position 0, so its effective width is fld_pos + 1.
- R8: Extracts drive carry_out to 0. Opcodes 6 and 7 give result 0 and carry_out 0, with out_valid still following in_valid.
- R9: With REG_OUT = 1, out_valid, result and carry_out appear one clock after the inputs are accepted. Whenever out_valid is 0, result and carry_out are 0.
- R10: A synchronous active-high reset clears out_valid, result and carry_out.
- R11: Multiplication by a constant can be built as a chain of these operations. Two chains are covered: x·10 as SH2ADD(x,x) then ADD(y,y), and x·120 as SH2ADD(x,x), SH1ADD(y,y), SH3ADD(y,0). Both give x·10 and x·120 mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 3 | Operation code (0 add, 1-3 shift-add, 4 unsigned extract, 5 signed extract) |
| src_a | input | 32 | First operand; source word for extracts |
| src_b | input | 32 | Second (addend) operand |
| fld_pos | input | 5 | Rightmost field bit, MSB-first numbering |
| fld_len_m1 | input | 5 | Field length minus one |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Carry of the add forms |

## Verification
The bench builds the unit with its defaults: a 32-bit data width and REG_OUT = 1. This makes the one-cycle latency and the zeroing of idle outputs observable at the ports. The full 5-bit position and length fields mean all 1024 position/length pairs can be swept for both fill modes, and that sweep covers every clipping case. With the full word width, carries out of bit 31 can be provoked and the wrap of the constant-multiply chains can be seen.

// File: rtl/sae_pkg.sv
package sae_pkg;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD    = 3'd0;
  localparam logic [OP_W-1:0] OP_SH1ADD = 3'd1;
  localparam logic [OP_W-1:0] OP_SH2ADD = 3'd2;
  localparam logic [OP_W-1:0] OP_SH3ADD = 3'd3;
  localparam logic [OP_W-1:0] OP_EXTU   = 3'd4;
  localparam logic [OP_W-1:0] OP_EXTS   = 3'd5;

  function automatic logic op_is_arith(input logic [OP_W-1:0] o);
    return o[2] == 1'b0;
  endfunction

  function automatic logic op_is_extract(input logic [OP_W-1:0] o);
    return (o == OP_EXTU) || (o == OP_EXTS);
  endfunction

endpackage

// File: rtl/sae_shift_add.sv
module sae_shift_add #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 2
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  localparam int NSH = 1 << SH_W;

  logic [DATA_W-1:0] shifted_opts [NSH];
  logic [DATA_W-1:0] scaled;

  // one pre-shifted copy per shift amount, picked by the mux below
  for (genvar k = 0; k < NSH; k++) begin : g_shift
    assign shifted_opts[k] = opnd_a << k;
  end

  assign scaled = shifted_opts[shamt];

  always_comb begin
    {cout, sum} = {1'b0, scaled} + {1'b0, opnd_b};
  end

endmodule

// File: rtl/sae_field_extract.sv
module sae_field_extract #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  len_m1,
  input  logic              sign_fill,
  output logic [DATA_W-1:0] res
);

  logic [POS_W-1:0]  lsb_idx;   // little-endian index of the field's right end
  logic [POS_W-1:0]  top_idx;   // clipped width minus one
  logic [DATA_W-1:0] aligned;
  logic              fill_bit;

  always_comb begin
    lsb_idx  = POS_W'(DATA_W - 1) - pos;
    // the field may not reach past the MSB (position 0)
    top_idx  = (len_m1 <= pos) ? len_m1 : pos;
    aligned  = src >> lsb_idx;
    fill_bit = sign_fill & aligned[top_idx];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign res[i] = (POS_W'(i) <= top_idx) ? aligned[i] : fill_bit;
  end

endmodule

// File: rtl/sae_out_stage.sv
module sae_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [DATA_W-1:0] d_in,
  input  logic              c_in,
  output logic              v_out,
  output logic [DATA_W-1:0] d_out,
  output logic              c_out
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_out <= 1'b0;
        d_out <= '0;
        c_out <= 1'b0;
      end else begin
        v_out <= v_in;
        d_out <= d_in;
        c_out <= c_in;
      end
    end
  end else begin : g_comb
    assign v_out = v_in;
    assign d_out = d_in;
    assign c_out = c_in;
  end

endmodule

// File: rtl/sae_unit.sv
module sae_unit #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [sae_pkg::OP_W-1:0]  op,
  input  logic [DATA_W-1:0]         src_a,
  input  logic [DATA_W-1:0]         src_b,
  input  logic [POS_W-1:0]          fld_pos,
  input  logic [POS_W-1:0]          fld_len_m1,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         result,
  output logic                      carry_out
);
  import sae_pkg::*;

  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic [DATA_W-1:0] ext_res;
  logic [DATA_W-1:0] sel_res;
  logic              sel_cout;

  sae_shift_add #(.DATA_W(DATA_W), .SH_W(2)) u_shadd (
    .opnd_a (src_a),
    .opnd_b (src_b),
    .shamt  (op[1:0]),
    .sum    (add_sum),
    .cout   (add_cout)
  );

  sae_field_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) u_extract (
    .src       (src_a),
    .pos       (fld_pos),
    .len_m1    (fld_len_m1),
    .sign_fill (op == OP_EXTS),
    .res       (ext_res)
  );

  // idle cycles and unused opcodes produce zeros
  always_comb begin
    sel_res  = '0;
    sel_cout = 1'b0;
    if (in_valid) begin
      if (op_is_arith(op)) begin
        sel_res  = add_sum;
        sel_cout = add_cout;
      end else if (op_is_extract(op)) begin
        sel_res  = ext_res;
      end
    end
  end

  sae_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .d_in  (sel_res),
    .c_in  (sel_cout),
    .v_out (out_valid),
    .d_out (result),
    .c_out (carry_out)
  );

  if (REG_OUT) begin : g_chk
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(in_valid)); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (result == '0 && !carry_out)); // R9

    AST_EXTRACT_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid && op_is_extract(op)) |-> !carry_out); // R8

    AST_ADD_DOUBLES: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid && op == OP_ADD && src_a == src_b)
        |-> result == DATA_W'($past(src_a) << 1)); // R3

    AST_UNSIGNED_ZERO_ABOVE: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid && op == OP_EXTU)
        |-> (result >> ($past({1'b0, fld_len_m1}) + 1'b1)) == '0); // R5
  end

endmodule

// File: tb/sae_unit_tb.sv
module sae_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  fld_pos = '0, fld_len_m1 = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sae_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .fld_pos(fld_pos), .fld_len_m1(fld_len_m1),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  // expected {carry, result}
  function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input int p, input int lm1);
    logic [32:0] r;
    logic [31:0] sa;
    int w;
    r = '0;
    if (o <= 3) begin
      sa = a << o;
      r = {1'b0, sa} + {1'b0, b};
    end else if (o == 4 || o == 5) begin
      w = lm1 + 1;
      if (w > p + 1) w = p + 1;
      for (int i = 0; i < 32; i++) begin
        if (i < w) r[i] = a[31 - p + i];
        else r[i] = (o == 5) ? a[31 - p + w - 1] : 1'b0;
      end
      r[32] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at next negedge
  task automatic run(input string req, input logic [2:0] o, input logic [31:0] a,
                     input logic [31:0] b, input int p, input int lm1,
                     output logic [31:0] res_o);
    op = o; src_a = a; src_b = b; fld_pos = 5'(p); fld_len_m1 = 5'(lm1);
    in_valid = 1'b1;
    @(negedge clk);
    check(req, {carry_out, result}, model(o, a, b, p, lm1));
    check({req, " valid"}, {32'd0, out_valid}, 33'd1);
    res_o = result;
  endtask

  initial begin
    logic [31:0] y, x;
    void'($urandom(32'h5AE1));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {carry_out, result}, 33'd0);
    check("R10 valid", {32'd0, out_valid}, 33'd0);
    rst = 1'b0;

    // R1 carry out of bit 31
    run("R1", 3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, y);
    run("R1", 3'd0, 32'h1234_5678, 32'h1111_1111, 0, 0, y);
    // R2 shifted-out bits do not reach carry; sum overflow does
    run("R2", 3'd3, 32'hF000_0001, 32'd7, 0, 0, y);
    run("R2", 3'd2, 32'h4000_0000, 32'hFFFF_FFFF, 0, 0, y);
    run("R2", 3'd1, 32'h8000_0000, 32'h8000_0000, 0, 0, y);
    // R3 doubling
    run("R3", 3'd0, 32'h8000_0003, 32'h8000_0003, 0, 0, y);
    // R6 halfword sign extension
    run("R6", 3'd5, 32'h1234_8001, 32'd0, 31, 15, y);
    run("R6", 3'd5, 32'h1234_7001, 32'd0, 31, 15, y);
    // R4 MSB-first numbering: field of 4 at positions 4..7
    run("R4", 3'd4, 32'h0A00_0000, 32'd0, 7, 3, y);
    // R7 clipping: p=3, len=8 -> 4 bits
    run("R7", 3'd5, 32'hB000_0000, 32'd0, 3, 7, y);
    run("R7", 3'd4, 32'hB000_0000, 32'd0, 3, 7, y);
    // R8 unused opcodes
    run("R8", 3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5, 5, y);
    run("R8", 3'd7, 32'hFFFF_FFFF, 32'd1, 31, 31, y);
    // R9 idle cycle zeroes outputs
    in_valid = 1'b0; src_a = 32'hFFFF_FFFF; src_b = 32'd1; op = 3'd0;
    @(negedge clk);
    check("R9 idle", {carry_out, result}, 33'd0);
    check("R9 idle valid", {32'd0, out_valid}, 33'd0);

    // random arithmetic, R1 R2 R3
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra;
      logic [2:0] ro;
      ra = $urandom;
      ro = 3'($urandom % 4);
      run(ro == 0 ? "R1" : "R2", ro, ra, (n % 8 == 0) ? ra : $urandom, 0, 0, y);
    end
    // R4 R5 R6 R7 all position/length pairs, both fills
    for (int p = 0; p < 32; p++)
      for (int l = 0; l < 32; l++) begin
        run("R5", 3'd4, $urandom, $urandom, p, l, y);
        run("R6", 3'd5, $urandom, $urandom, p, l, y);
      end

    // R11 constant multiply chains
    for (int n = 0; n < 8; n++) begin
      x = (n == 0) ? 32'hFFFF_FFFF : $urandom;
      run("R11 x10 step1", 3'd2, x, x, 0, 0, y);
      run("R11 x10 step2", 3'd0, y, y, 0, 0, y);
      check("R11 x10", {1'b0, y}, {1'b0, x * 32'd10});
      run("R11 x120 step1", 3'd2, x, x, 0, 0, y);
      run("R11 x120 step2", 3'd1, y, y, 0, 0, y);
      run("R11 x120 step3", 3'd3, y, 32'd0, 0, 0, y);
      check("R11 x120", {1'b0, y}, {1'b0, x * 32'd120});
    end

    in_valid = 1'b0;
    @(negedge clk);
    // R10 synchronous reset clears registered outputs
    in_valid = 1'b1; op = 3'd0; src_a = 32'h7; src_b = 32'h9;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 sync", {carry_out, result}, 33'd0);
    check("R10 sync valid", {32'd0, out_valid}, 33'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule